// File: doc/BRIEF.md
# Partitioned Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for a processor that runs several partitions side by side. Every entry can be compared against a request in the same cycle. An entry belongs to one partition. It is either a real translation, which is shared by all contexts of that partition, or a context translation, which is private to one context. Pages come in eight sizes. Size code `s` covers 8^s base pages, so the low `3*s` bits of the virtual page number select an offset inside the page.

A maintenance port carries one command per cycle. The command is an insert, a demap of a single page, a demap of a context, or a demap of a whole partition. The lookup port is combinational: it returns the hit flag and the translated page in the cycle the request is presented. A diagnostic port reads the tag word and the data word of any entry by index.

Each entry has a used bit, and replacement is driven by it. A lookup marks the entry it hits, and so does an insert. Whenever the used bits would all be set, every bit except the newest is cleared, so that an unused victim always remains. Locked entries are never chosen as victims while an unlocked entry exists, and they survive a partition-wide demap.

Top module: `ptlb`

## Requirements
- R1: After reset no entry is valid, every lookup misses, and a tag or data read of any index returns all ones.
- R2: An insert clears the low `3*size` bits of the virtual page number before storing it. The stored value is visible in the tag read.
- R3: An insert (command code 0) invalidates every valid entry whose page range overlaps the new one and that has the same real flag and partition, and also the same context when the entry is not real.
- R4: An insert with `cmd_at_idx` set writes entry `cmd_idx`, which must be below ENTRIES.
- R5: An insert without an explicit index picks, in order: the lowest index that is invalid or unused and unlocked; else the lowest index that is not a valid locked entry; else the last index. Entries invalidated by the same insert count as invalid.
- R6: A written entry becomes valid and used. If its used bit would leave every used bit set, only the new entry keeps its used bit.
- R7: A lookup hits an entry that is valid, has the same partition and real flag and the same page under the entry's size, and also the same context when the lookup is not real. In the same cycle it outputs `lk_hit`, the size, the lock flag, and the translated page: the physical page with its low `3*size` bits taken from the lookup page.
- R8: A hit with `lk_upd` set marks the hit entry used at the next clock edge, under the same all-used rule as R6.
- R9: Demap page (command code 1) invalidates the entries that a lookup with the same fields would hit.
- R10: Demap context (command code 2) invalidates every valid entry of the given partition and context, locked or not.
- R11: Demap all (command code 3) invalidates every valid unlocked entry of the given partition. Locked entries and other partitions are kept.
- R12: A valid tag read returns the partition in bits 63:61, the inverted size code in bits 58:56, the page number from bit 13 up, and the context in bits 12:0. All other bits are zero.
- R13: A valid data read returns the physical page from bit 0, the size in bits 50:48, the real flag in bit 51, the used flag in bit 52 and the lock flag in bit 53. All other bits are zero.
- R14: When a lookup and a command share a cycle, the lookup sees the state from before the command. An entry that the command invalidates does not keep the used bit the lookup would have set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_part | input | PART_W | Lookup partition |
| lk_ctx | input | CTX_W | Lookup context |
| lk_real | input | 1 | Lookup is a real translation |
| lk_upd | input | 1 | Mark the hit entry used |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Translated page number |
| lk_size | output | 3 | Size code of the hit entry |
| lk_locked | output | 1 | Hit entry is locked |
| cmd_req | input | 1 | Command valid |
| cmd_op | input | 2 | 0 insert, 1 demap page, 2 demap context, 3 demap all |
| cmd_vpn | input | VPN_W | Command virtual page number |
| cmd_part | input | PART_W | Command partition |
| cmd_ctx | input | CTX_W | Command context |
| cmd_real | input | 1 | Command real flag |
| cmd_size | input | 3 | Insert size code |
| cmd_ppn | input | PPN_W | Insert physical page |
| cmd_lock | input | 1 | Insert lock flag |
| cmd_at_idx | input | 1 | Insert at explicit index |
| cmd_idx | input | IDX_W | Explicit insert index |
| rd_idx | input | IDX_W | Diagnostic read index |
| rd_tag | output | 64 | Tag word of entry `rd_idx` |
| rd_data | output | 64 | Data word of entry `rd_idx` |

## Verification
A lookup and a maintenance command can fall in the same cycle. The bench provokes this in two ways. First, it hits an entry with `lk_upd` set while a demap page removes that same entry. It judges that `lk_hit` still reports the old state before the edge, and that the entry is gone after it. Second, it hits one entry while an explicit insert writes another. It judges through the data reads that both entries come out used.

// File: rtl/ptlb.sv
module ptlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 28,
  parameter int PPN_W   = 28,
  parameter int CTX_W   = 13,
  parameter int PART_W  = 3,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PART_W-1:0] lk_part,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              lk_real,
  input  logic              lk_upd,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [2:0]        lk_size,
  output logic              lk_locked,
  input  logic              cmd_req,
  input  logic [1:0]        cmd_op,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [PART_W-1:0] cmd_part,
  input  logic [CTX_W-1:0]  cmd_ctx,
  input  logic              cmd_real,
  input  logic [2:0]        cmd_size,
  input  logic [PPN_W-1:0]  cmd_ppn,
  input  logic              cmd_lock,
  input  logic              cmd_at_idx,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [63:0]       rd_tag,
  output logic [63:0]       rd_data
);

  function automatic logic [VPN_W-1:0] vmask(input logic [2:0] s);
    return {VPN_W{1'b1}} << (3 * s);
  endfunction

  function automatic logic [PPN_W-1:0] pmask(input logic [2:0] s);
    return {PPN_W{1'b1}} << (3 * s);
  endfunction

  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
  logic [ENTRIES-1:0][CTX_W-1:0]  e_ctx;
  logic [ENTRIES-1:0][PART_W-1:0] e_part;
  logic [ENTRIES-1:0][2:0]        e_size;
  logic [ENTRIES-1:0] valid_q, used_q, locked_q, real_q;

  logic [ENTRIES-1:0] lk_match, dm_page, dm_ctx, dm_all, conflict, kill;
  logic [ENTRIES-1:0] valid_post, used_post, free_vec, unl_vec;
  logic [ENTRIES-1:0] used_set, used_tmp, wr_hot, recent, used_n;
  logic [IDX_W-1:0]   victim, wr_idx;
  logic               wr_en;

  assign wr_en = cmd_req && (cmd_op == 2'd0);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [2:0] big;
    assign big = (e_size[i] > cmd_size) ? e_size[i] : cmd_size;
    assign lk_match[i] = lk_req && valid_q[i] && e_part[i] == lk_part &&
                         real_q[i] == lk_real && (lk_real || e_ctx[i] == lk_ctx) &&
                         ((e_vpn[i] ^ lk_vpn) & vmask(e_size[i])) == '0;
    assign dm_page[i]  = valid_q[i] && e_part[i] == cmd_part &&
                         real_q[i] == cmd_real && (cmd_real || e_ctx[i] == cmd_ctx) &&
                         ((e_vpn[i] ^ cmd_vpn) & vmask(e_size[i])) == '0;
    assign dm_ctx[i]   = valid_q[i] && e_part[i] == cmd_part && e_ctx[i] == cmd_ctx;
    assign dm_all[i]   = valid_q[i] && !locked_q[i] && e_part[i] == cmd_part;
    assign conflict[i] = valid_q[i] && e_part[i] == cmd_part &&
                         real_q[i] == cmd_real && (cmd_real || e_ctx[i] == cmd_ctx) &&
                         ((e_vpn[i] ^ cmd_vpn) & vmask(big)) == '0;
  end

  always_comb begin
    kill = '0;
    if (cmd_req) begin
      case (cmd_op)
        2'd0:    kill = conflict;
        2'd1:    kill = dm_page;
        2'd2:    kill = dm_ctx;
        default: kill = dm_all;
      endcase
    end
  end

  assign valid_post = valid_q & ~kill;
  assign used_post  = used_q & ~kill;
  assign free_vec   = ~valid_post | (~used_post & ~locked_q);
  assign unl_vec    = ~(valid_post & locked_q);

  always_comb begin
    victim = IDX_W'(ENTRIES - 1);
    for (int i = ENTRIES - 1; i >= 0; i--) if (unl_vec[i]) victim = IDX_W'(i);
    for (int i = ENTRIES - 1; i >= 0; i--) if (free_vec[i]) victim = IDX_W'(i);
  end

  assign wr_idx   = cmd_at_idx ? cmd_idx : victim;
  assign wr_hot   = wr_en ? (ENTRIES'(1) << wr_idx) : '0;
  assign used_set = (lk_upd ? lk_match : '0) & ~kill;
  assign used_tmp = used_post | used_set | wr_hot;
  assign recent   = wr_en ? wr_hot : used_set;
  assign used_n   = (&used_tmp) ? recent : used_tmp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      used_q   <= '0;
      locked_q <= '0;
    end else begin
      valid_q <= valid_post | wr_hot;
      used_q  <= used_n;
      if (wr_en) locked_q[wr_idx] <= cmd_lock;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vpn <= '0; e_ppn <= '0; e_ctx <= '0;
      e_part <= '0; e_size <= '0; real_q <= '0;
    end else if (wr_en) begin
      e_vpn[wr_idx]  <= cmd_vpn & vmask(cmd_size);
      e_ppn[wr_idx]  <= cmd_ppn;
      e_ctx[wr_idx]  <= cmd_ctx;
      e_part[wr_idx] <= cmd_part;
      e_size[wr_idx] <= cmd_size;
      real_q[wr_idx] <= cmd_real;
    end
  end

  logic [PPN_W-1:0] hit_ppn;
  always_comb begin
    hit_ppn   = '0;
    lk_size   = '0;
    lk_locked = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        hit_ppn   = hit_ppn | e_ppn[i];
        lk_size   = lk_size | e_size[i];
        lk_locked = lk_locked | locked_q[i];
      end
    end
  end

  assign lk_hit = |lk_match;
  assign lk_ppn = (hit_ppn & pmask(lk_size)) | (PPN_W'(lk_vpn) & ~pmask(lk_size));

  assign rd_tag = !valid_q[rd_idx] ? '1 :
                  (64'(e_part[rd_idx]) << 61) | (64'(~e_size[rd_idx]) << 56) |
                  (64'(e_vpn[rd_idx]) << 13) | 64'(e_ctx[rd_idx]);
  assign rd_data = !valid_q[rd_idx] ? '1 :
                   64'(e_ppn[rd_idx]) | (64'(e_size[rd_idx]) << 48) |
                   (64'(real_q[rd_idx]) << 51) | (64'(used_q[rd_idx]) << 52) |
                   (64'(locked_q[rd_idx]) << 53);

endmodule

// File: rtl/ptlb_chk.sv
module ptlb_chk #(
  parameter int N      = 16,
  parameter int IDX_W  = 4,
  parameter int PART_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N-1:0]             valid_q,
  input logic [N-1:0]             used_q,
  input logic [N-1:0]             locked_q,
  input logic [N-1:0]             lk_match,
  input logic [N-1:0]             kill,
  input logic [N-1:0][PART_W-1:0] e_part,
  input logic                     wr_en,
  input logic [IDX_W-1:0]         wr_idx,
  input logic                     lk_upd,
  input logic                     lk_hit,
  input logic                     cmd_req,
  input logic [1:0]               cmd_op,
  input logic [PART_W-1:0]        cmd_part
);
  logic [PART_W-1:0] prev_part;
  logic [N-1:0]      pm;

  always_ff @(posedge clk) prev_part <= cmd_part;
  always_comb for (int i = 0; i < N; i++) pm[i] = (e_part[i] == prev_part);

  p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  p_write_valid_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)] && used_q[$past(wr_idx)]);

  if (N > 1) begin : g_nf
    p_used_never_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(&used_q));
  end

  p_used_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_upd && !cmd_req) |=> |(used_q & $past(lk_match)));

  p_demap_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_op != 2'd0) |=> ~|(valid_q & $past(kill)));

  p_demap_all_part_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_op == 2'd3) |=> ~|(valid_q & ~locked_q & pm));

  p_locked_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_op == 2'd3) |=> (valid_q & locked_q) == $past(valid_q & locked_q));
endmodule

bind ptlb ptlb_chk #(.N(ENTRIES), .IDX_W(IDX_W), .PART_W(PART_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .used_q(used_q),
  .locked_q(locked_q), .lk_match(lk_match), .kill(kill), .e_part(e_part),
  .wr_en(wr_en), .wr_idx(wr_idx), .lk_upd(lk_upd), .lk_hit(lk_hit),
  .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_part(cmd_part)
);

// File: tb/ptlb_tb.sv
module ptlb_tb_top;
  localparam int IW = 4;
  logic clk = 0, rst_n = 0;
  logic lk_req = 0, lk_real = 0, lk_upd = 0;
  logic [27:0] lk_vpn = 0;
  logic [2:0] lk_part = 0;
  logic [12:0] lk_ctx = 0;
  logic lk_hit, lk_locked;
  logic [27:0] lk_ppn;
  logic [2:0] lk_size;
  logic cmd_req = 0, cmd_real = 0, cmd_lock = 0, cmd_at_idx = 0;
  logic [1:0] cmd_op = 0;
  logic [27:0] cmd_vpn = 0, cmd_ppn = 0;
  logic [2:0] cmd_part = 0, cmd_size = 0;
  logic [12:0] cmd_ctx = 0;
  logic [IW-1:0] cmd_idx = 0, rd_idx = 0;
  logic [63:0] rd_tag, rd_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ptlb dut_i (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cmd_req = 0; lk_req = 0; lk_upd = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic issue(input logic [1:0] op, input logic [27:0] vpn, input logic [2:0] part,
                       input logic [12:0] ctx, input logic rl, input logic [2:0] sz,
                       input logic [27:0] ppn, input logic lk, input logic at, input int idx);
    cmd_op = op; cmd_vpn = vpn; cmd_part = part; cmd_ctx = ctx; cmd_real = rl;
    cmd_size = sz; cmd_ppn = ppn; cmd_lock = lk; cmd_at_idx = at; cmd_idx = IW'(idx);
    cmd_req = 1;
    @(posedge clk); #1 cmd_req = 0;
  endtask

  task automatic probe(input logic [27:0] vpn, input logic [2:0] part,
                       input logic [12:0] ctx, input logic rl);
    lk_req = 1; lk_vpn = vpn; lk_part = part; lk_ctx = ctx; lk_real = rl; lk_upd = 0;
    #1;
  endtask

  task automatic rd(input int idx);
    rd_idx = IW'(idx); #1;
  endtask

  function automatic logic [63:0] tagv(logic [2:0] p, logic [2:0] s, logic [27:0] v, logic [12:0] c);
    return (64'(p) << 61) | (64'(~s) << 56) | (64'(v) << 13) | 64'(c);
  endfunction

  task automatic t_reset();
    do_reset();
    probe(28'h10, 0, 0, 0); check("R1 miss", 64'(lk_hit), 0);
    probe(28'h10, 0, 0, 1); check("R1 real miss", 64'(lk_hit), 0);
    rd(0);  check("R1 tag", rd_tag, '1);
    rd(15); check("R1 data", rd_data, '1);
    lk_req = 0;
  endtask

  task automatic t_insert_lookup();
    do_reset();
    issue(0, 28'h123457, 2, 13'h55, 0, 1, 28'hABCDE0, 0, 1, 3);
    rd(3);
    check("R2 R4 R12 tag", rd_tag, tagv(2, 1, 28'h123450, 13'h55));
    check("R13 R6 data", rd_data, 64'hABCDE0 | (64'd1 << 48) | (64'd1 << 52));
    probe(28'h123452, 2, 13'h55, 0);
    check("R7 hit", 64'(lk_hit), 1);
    check("R7 ppn", 64'(lk_ppn), 64'hABCDE2);
    check("R7 size", 64'(lk_size), 1);
    probe(28'h123452, 2, 13'h56, 0); check("R7 ctx miss", 64'(lk_hit), 0);
    probe(28'h123452, 1, 13'h55, 0); check("R7 part miss", 64'(lk_hit), 0);
    probe(28'h123452, 2, 13'h55, 1); check("R7 real miss", 64'(lk_hit), 0);
    lk_req = 0;
    issue(0, 28'h200, 2, 13'h7, 1, 0, 28'h900, 1, 1, 4);
    probe(28'h200, 2, 13'h3, 1);
    check("R7 real any ctx", 64'(lk_hit), 1);
    check("R7 real ppn", 64'(lk_ppn), 64'h900);
    check("R7 locked", 64'(lk_locked), 1);
    lk_req = 0;
  endtask

  task automatic t_conflict();
    do_reset();
    issue(0, 28'h123457, 2, 13'h55, 0, 1, 28'h1000, 0, 1, 3);
    issue(0, 28'h123450, 2, 13'h56, 0, 0, 28'h2000, 0, 1, 5);
    issue(0, 28'h123452, 2, 13'h55, 0, 0, 28'h3000, 0, 0, 0);
    rd(3); check("R3 overlap removed", rd_tag, '1);
    rd(5); check("R3 other ctx kept", rd_tag, tagv(2, 0, 28'h123450, 13'h56));
    rd(0); check("R5 lowest free", rd_tag, tagv(2, 0, 28'h123452, 13'h55));
  endtask

  task automatic t_replace();
    do_reset();
    for (int i = 0; i < 16; i++) issue(0, 28'(16'h400 + i), 0, 1, 0, 0, 28'(i), 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      rd(i); check("R5 fill order", rd_tag, tagv(0, 0, 28'(16'h400 + i), 1));
    end
    rd(5);  check("R6 used cleared", 64'(rd_data[52]), 0);
    rd(15); check("R6 newest used", 64'(rd_data[52]), 1);
    issue(0, 28'h777, 0, 1, 0, 0, 28'h1, 0, 0, 0);
    rd(0); check("R5 unused victim", rd_tag, tagv(0, 0, 28'h777, 1));
    do_reset();
    for (int i = 0; i < 16; i++) issue(0, 28'(16'h500 + i), 0, 1, 0, 0, 0, 1, 1, i);
    issue(0, 28'h888, 0, 1, 0, 0, 0, 0, 0, 0);
    rd(15); check("R5 all locked last", rd_tag, tagv(0, 0, 28'h888, 1));
    do_reset();
    for (int i = 0; i < 16; i++) issue(0, 28'(16'h500 + i), 0, 1, 0, 0, 0, (i != 5), 1, i);
    lk_req = 1; lk_vpn = 28'h505; lk_part = 0; lk_ctx = 1; lk_real = 0; lk_upd = 1;
    @(posedge clk); #1 lk_req = 0; lk_upd = 0;
    rd(5); check("R8 used set", 64'(rd_data[52]), 1);
    issue(0, 28'h999, 0, 1, 0, 0, 0, 0, 0, 0);
    rd(5); check("R5 first unlocked", rd_tag, tagv(0, 0, 28'h999, 1));
  endtask

  task automatic t_demap();
    do_reset();
    issue(0, 28'h10, 1, 5, 0, 0, 0, 0, 1, 0);
    issue(0, 28'h20, 1, 5, 0, 0, 0, 1, 1, 1);
    issue(0, 28'h30, 1, 6, 0, 0, 0, 0, 1, 2);
    issue(0, 28'h40, 2, 5, 0, 0, 0, 0, 1, 3);
    issue(0, 28'h50, 1, 9, 0, 0, 0, 1, 1, 4);
    issue(0, 28'h60, 1, 0, 1, 0, 0, 0, 1, 5);
    issue(1, 28'h10, 1, 5, 0, 0, 0, 0, 0, 0);
    probe(28'h10, 1, 5, 0); check("R9 page gone", 64'(lk_hit), 0);
    probe(28'h20, 1, 5, 0); check("R9 neighbour kept", 64'(lk_hit), 1);
    lk_req = 0;
    issue(2, 0, 1, 5, 0, 0, 0, 0, 0, 0);
    rd(1); check("R10 locked ctx removed", rd_tag, '1);
    rd(3); check("R10 other part kept", rd_tag, tagv(2, 0, 28'h40, 5));
    rd(2); check("R10 other ctx kept", rd_tag, tagv(1, 0, 28'h30, 6));
    issue(3, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    rd(2); check("R11 unlocked removed", rd_tag, '1);
    rd(5); check("R11 real removed", rd_tag, '1);
    rd(4); check("R11 locked kept", rd_tag, tagv(1, 0, 28'h50, 9));
    rd(3); check("R11 other part kept", rd_tag, tagv(2, 0, 28'h40, 5));
  endtask

  task automatic t_same_cycle();
    do_reset();
    issue(0, 28'h70, 0, 1, 0, 0, 28'h5, 0, 1, 0);
    issue(0, 28'h80, 0, 1, 0, 0, 28'h6, 0, 1, 1);
    issue(0, 28'h90, 0, 1, 0, 0, 28'h7, 0, 1, 2);
    lk_req = 1; lk_vpn = 28'h70; lk_part = 0; lk_ctx = 1; lk_real = 0; lk_upd = 1;
    cmd_op = 1; cmd_vpn = 28'h70; cmd_part = 0; cmd_ctx = 1; cmd_real = 0; cmd_req = 1;
    #1 check("R14 lookup sees old state", 64'(lk_hit), 1);
    @(posedge clk); #1 cmd_req = 0;
    check("R14 demap wins", 64'(lk_hit), 0);
    rd(0); check("R14 entry gone", rd_tag, '1);
    do_reset();
    issue(0, 28'h70, 0, 1, 0, 0, 28'h5, 0, 1, 0);
    for (int i = 1; i < 16; i++) issue(0, 28'(16'h600 + i), 0, 1, 0, 0, 0, 0, 1, i);
    lk_req = 1; lk_vpn = 28'h70; lk_part = 0; lk_ctx = 1; lk_real = 0; lk_upd = 1;
    cmd_op = 0; cmd_vpn = 28'hA0; cmd_part = 0; cmd_ctx = 2; cmd_size = 0;
    cmd_at_idx = 1; cmd_idx = 4; cmd_lock = 0; cmd_req = 1;
    @(posedge clk); #1 cmd_req = 0; lk_req = 0; lk_upd = 0;
    rd(0); check("R14 R8 hit entry used", 64'(rd_data[52]), 1);
    rd(4); check("R14 R6 written entry used", 64'(rd_data[52]), 1);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_insert_lookup();
    t_conflict();
    t_replace();
    t_demap();
    t_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule